// File: doc/BRIEF.md
# Flash Program/Erase Command Controller

This block sits in front of a small on-chip flash array, modelled as synthesizable storage, and runs the commands that software or a host engine issues through a one-cycle command strobe. It reads a byte, programs a byte or an aligned 16-bit word, and erases a page, a whole section, or every erasable location at once. Programming can only pull bits from 1 to 0. Every byte may be programmed once between two erases that cover it. A single access-enable input locks out everything but the whole-array erase.

The address space has three regions. A main area holds `MAIN_SECTIONS` sections of `MAIN_PAGES_PER_SECTION` pages of `MAIN_PAGE_BYTES` each. An information area follows it, with `INFO_SECTIONS` sections of `INFO_PAGES_PER_SECTION` pages of `INFO_PAGE_BYTES` each. A read-only factory area of `FACTORY_BYTES` comes last. An erase walks its range one location per clock. It waits `PAGE_DELAY` cycles at the start of each page, then re-reads the whole range to verify it. Busy is high for the entire erase. At the end the erase error flag shows whether any location failed to read back as all ones. A fault-injection input can hold one chosen location at zero during an erase, so that the error path can be exercised.

Every command taken while idle gives exactly one response pulse, which carries a refusal bit. A command that arrives during an erase gets no response. Instead it sets a sticky rejected flag, and software clears that flag by writing a 1 to the clear input.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, busy, eraseErr, cmdRejected and rspValid are 0. Main and information bytes read 0xFF. The factory byte at offset k from the factory base (address 96 by default) reads 0xA0+k.
- R2: A command taken while idle produces rspValid for exactly the cycle after it is sampled. For an accepted read (cmdOp 0), rdData holds the addressed byte in that cycle and rspErr is 0.
- R3: A byte program (cmdOp 1) stores the old byte AND cmdData[7:0], so no bit ever goes from 0 to 1.
- R4: A word program (cmdOp 2) needs an even address. It writes cmdData[7:0] to that address and cmdData[15:8] to the next address. An odd address is refused and nothing changes.
- R5: A program that targets a byte already programmed since its last erase is refused (rspErr 1) and leaves the contents unchanged. For a word, this applies if either of its two bytes is already programmed.
- R6: A page erase (cmdOp 3) sets every byte of the addressed page to 0xFF and makes those bytes programmable again. Pages are 16 bytes in the main area (addresses 0 to 63) and 8 bytes in the information area (64 to 95). Bytes outside the page are untouched.
- R7: A section erase (cmdOp 4) erases every page of the addressed section: main sections of 32 bytes, information sections of 16 bytes.
- R8: A whole-array erase (cmdOp 5) sets addresses 0 to 95 to 0xFF and leaves the factory area unchanged.
- R9: An accepted erase answers with rspErr 0 and raises busy in the same cycle. Busy stays high for PAGE_DELAY cycles per page, plus one cycle per byte erased, plus one cycle per byte verified. When busy falls, eraseErr is 1 exactly when some byte in the range did not read 0xFF. eraseErr changes at no other time except when the next erase starts, which clears it.
- R10: While accessEn is 0, reads, programs, page erases and section erases are refused with rspErr 1. Only the whole-array erase is accepted.
- R11: A command that arrives while busy is ignored and gives no response. It sets cmdRejected, which stays set until a cycle with rejClr high.
- R12: Programs, page erases and section erases that target the factory area are refused. So are commands to addresses at or beyond 104, and cmdOp values 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 3 | Command code (0 read, 1 byte program, 2 word program, 3 page erase, 4 section erase, 5 whole-array erase) |
| cmdAddr | input | AW | Byte address of the command |
| cmdData | input | 16 | Program data (low byte at cmdAddr) |
| accessEn | input | 1 | Access enable; when 0 only the whole-array erase is taken |
| rejClr | input | 1 | Write-1 clear of cmdRejected |
| faultEn | input | 1 | Enables the stuck-at-zero fault for erases |
| faultAddr | input | AW | Location that stays 0x00 when erased with faultEn set |
| rspValid | output | 1 | Response pulse for each command taken while idle |
| rspErr | output | 1 | The command was refused |
| rdData | output | 8 | Read data, valid with rspValid of a read |
| busy | output | 1 | Erase in progress |
| eraseErr | output | 1 | Verify result of the last erase |
| cmdRejected | output | 1 | Sticky: a command arrived while busy |

## Verification
Programs are tried with bit patterns that clear disjoint bit groups on a repeated write. This separates a true AND from a plain overwrite, and it also separates that AND from the write-once refusal. Erases are run at page, section and whole-array granularity, in both page sizes. Bytes are programmed just outside each range first, so an off-by-one range or the wrong page size shows up as a changed neighbour or a wrong busy length. The stuck-at fault is placed inside one erase range and then cleared for a repeat erase of the same page, which shows whether eraseErr follows the verify result or only the fault input. Each refusal condition is applied on its own (access disabled, factory target, odd word address, out-of-range address, unknown code), so that each refusal is checked separately from the others.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_READ       = 3'd0,
    OP_PROG_BYTE  = 3'd1,
    OP_PROG_WORD  = 3'd2,
    OP_ERASE_PAGE = 3'd3,
    OP_ERASE_SECT = 3'd4,
    OP_ERASE_ALL  = 3'd5
  } flashOp_e;

  typedef enum logic [1:0] {
    RGN_MAIN,
    RGN_INFO,
    RGN_FACT,
    RGN_NONE
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ERASE,
    ST_VERIFY
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rdLatch;
    logic wrByte;
    logic wrWord;
    logic eraseLoc;
    logic verifyLoc;
  } strobe_t;

endpackage

// File: rtl/flash_addr_map.sv
module flash_addr_map
  import flash_cmd_pkg::*;
#(
  parameter int MAIN_PAGE_BYTES        = 16,
  parameter int MAIN_PAGES_PER_SECTION = 2,
  parameter int MAIN_SECTIONS          = 2,
  parameter int INFO_PAGE_BYTES        = 8,
  parameter int INFO_PAGES_PER_SECTION = 2,
  parameter int INFO_SECTIONS          = 2,
  parameter int FACTORY_BYTES          = 8,
  parameter int AW                     = 7
) (
  input  logic [AW-1:0] cmdAddr,
  input  logic [AW-1:0] walkNext,
  output region_e       region,
  output logic [AW-1:0] pageFirst,
  output logic [AW-1:0] pageLast,
  output logic [AW-1:0] secFirst,
  output logic [AW-1:0] secLast,
  output logic          walkPageStart
);

  localparam int MAIN_SEC_BYTES = MAIN_PAGE_BYTES * MAIN_PAGES_PER_SECTION;
  localparam int INFO_SEC_BYTES = INFO_PAGE_BYTES * INFO_PAGES_PER_SECTION;
  localparam int MAIN_BYTES     = MAIN_SEC_BYTES * MAIN_SECTIONS;
  localparam int ARRAY_BYTES    = MAIN_BYTES + INFO_SEC_BYTES * INFO_SECTIONS;
  localparam int TOTAL_BYTES    = ARRAY_BYTES + FACTORY_BYTES;

  // decode the command address into its region, page and section bounds
  always_comb begin
    int a;
    int off;
    int pb;
    int sb;
    a         = int'(cmdAddr);
    off       = 0;
    pb        = 0;
    sb        = 0;
    region    = RGN_NONE;
    if (a < MAIN_BYTES) begin
      region = RGN_MAIN;
      pb     = a - (a % MAIN_PAGE_BYTES);
      sb     = a - (a % MAIN_SEC_BYTES);
    end else if (a < ARRAY_BYTES) begin
      region = RGN_INFO;
      off    = a - MAIN_BYTES;
      pb     = MAIN_BYTES + off - (off % INFO_PAGE_BYTES);
      sb     = MAIN_BYTES + off - (off % INFO_SEC_BYTES);
    end else if (a < TOTAL_BYTES) begin
      region = RGN_FACT;
    end
    pageFirst = AW'(pb);
    secFirst  = AW'(sb);
    pageLast  = (region == RGN_MAIN) ? AW'(pb + MAIN_PAGE_BYTES - 1) : AW'(pb + INFO_PAGE_BYTES - 1);
    secLast   = (region == RGN_MAIN) ? AW'(sb + MAIN_SEC_BYTES - 1) : AW'(sb + INFO_SEC_BYTES - 1);
  end

  // does the next walk location open a new page
  always_comb begin
    int w;
    w = int'(walkNext);
    if (w < MAIN_BYTES)       walkPageStart = ((w % MAIN_PAGE_BYTES) == 0);
    else if (w < ARRAY_BYTES) walkPageStart = (((w - MAIN_BYTES) % INFO_PAGE_BYTES) == 0);
    else                      walkPageStart = 1'b1;
  end

endmodule

// File: rtl/flash_datapath.sv
module flash_datapath
  import flash_cmd_pkg::*;
#(
  parameter int TOTAL_BYTES = 104,
  parameter int FACT_BASE   = 96,
  parameter int AW          = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] cmdAddr,
  input  logic [15:0]   cmdData,
  input  logic [AW-1:0] walkAddr,
  input  logic          faultEn,
  input  logic [AW-1:0] faultAddr,
  output logic [7:0]    rdData,
  output logic          progLo,
  output logic          progHi,
  output logic          walkFail
);

  localparam logic [AW:0] TOT = (AW+1)'(TOTAL_BYTES);

  logic [7:0]             memQ [TOTAL_BYTES];
  logic [TOTAL_BYTES-1:0] progQ;
  logic [AW-1:0]          hiAddr;
  logic [AW-1:0]          loIdx;
  logic [AW-1:0]          hiIdx;
  logic [AW-1:0]          wIdx;
  logic [7:0]             loByte;
  logic [7:0]             hiByte;
  logic [7:0]             walkByte;
  logic                   faultHit;

  assign hiAddr   = cmdAddr + AW'(1);
  assign loIdx    = ({1'b0, cmdAddr}  < TOT) ? cmdAddr  : '0;
  assign hiIdx    = ({1'b0, hiAddr}   < TOT) ? hiAddr   : '0;
  assign wIdx     = ({1'b0, walkAddr} < TOT) ? walkAddr : '0;
  assign loByte   = memQ[loIdx];
  assign hiByte   = memQ[hiIdx];
  assign walkByte = memQ[wIdx];
  assign progLo   = progQ[loIdx];
  assign progHi   = progQ[hiIdx];
  assign walkFail = strb.verifyLoc && (walkByte != 8'hFF);
  assign faultHit = faultEn && (faultAddr == walkAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL_BYTES; i++) begin
        memQ[i] <= (i >= FACT_BASE) ? 8'(8'hA0 + i - FACT_BASE) : 8'hFF;
      end
      progQ  <= '0;
      rdData <= '0;
    end else begin
      if (strb.rdLatch) rdData <= loByte;
      if (strb.wrByte || strb.wrWord) begin
        memQ[loIdx]  <= loByte & cmdData[7:0];
        progQ[loIdx] <= 1'b1;
      end
      if (strb.wrWord) begin
        memQ[hiIdx]  <= hiByte & cmdData[15:8];
        progQ[hiIdx] <= 1'b1;
      end
      if (strb.eraseLoc) begin
        memQ[wIdx]  <= faultHit ? 8'h00 : 8'hFF;
        progQ[wIdx] <= 1'b0;
      end
    end
  end

  // R3: a byte program never raises a bit
  p_clear_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrByte |=> ((memQ[$past(loIdx)] & ~$past(loByte)) == 8'h00));

  // R5: control never programs a byte that is already tracked
  p_write_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte || strb.wrWord) |-> !progLo);

  // R6: an erased location becomes programmable again
  p_erase_untrack_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseLoc |=> !progQ[$past(wIdx)]);

endmodule

// File: rtl/flash_control.sv
module flash_control
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 7,
  parameter int ARRAY_BYTES = 96,
  parameter int PAGE_DELAY  = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic          cmdAddrLsb,
  input  logic          accessEn,
  input  logic          rejClr,
  input  region_e       region,
  input  logic [AW-1:0] pageFirst,
  input  logic [AW-1:0] pageLast,
  input  logic [AW-1:0] secFirst,
  input  logic [AW-1:0] secLast,
  input  logic          walkPageStart,
  input  logic          progLo,
  input  logic          progHi,
  input  logic          walkFail,
  output strobe_t       strb,
  output logic [AW-1:0] walkAddr,
  output logic          busy,
  output logic          rspValid,
  output logic          rspErr,
  output logic          eraseErr,
  output logic          cmdRejected
);

  localparam int            DW         = $clog2(PAGE_DELAY + 1);
  localparam logic [DW-1:0] DELAY_LOAD = DW'(PAGE_DELAY - 1);
  localparam logic [AW-1:0] ALL_LAST   = AW'(ARRAY_BYTES - 1);

  ctrlState_e    stateQ;
  logic [AW-1:0] firstQ;
  logic [AW-1:0] lastQ;
  logic [DW-1:0] delayQ;
  logic          errAccQ;
  logic          isIdle;
  logic          take;
  logic          opOk;
  logic          isErase;
  logic          startErase;
  logic          atLast;
  logic [AW-1:0] rangeFirst;
  logic [AW-1:0] rangeLast;
  logic          badAddr;
  logic          isFact;

  assign isIdle  = (stateQ == ST_IDLE);
  assign busy    = !isIdle;
  assign take    = cmdValid && isIdle;
  assign badAddr = (region == RGN_NONE);
  assign isFact  = (region == RGN_FACT);
  assign atLast  = (walkAddr == lastQ);

  // acceptance of a command taken while idle
  always_comb begin
    opOk       = 1'b0;
    isErase    = 1'b0;
    rangeFirst = '0;
    rangeLast  = ALL_LAST;
    case (cmdOp)
      OP_READ:       opOk = accessEn && !badAddr;
      OP_PROG_BYTE:  opOk = accessEn && !badAddr && !isFact && !progLo;
      OP_PROG_WORD:  opOk = accessEn && !badAddr && !isFact && !cmdAddrLsb && !progLo && !progHi;
      OP_ERASE_PAGE: begin
        opOk       = accessEn && !badAddr && !isFact;
        isErase    = 1'b1;
        rangeFirst = pageFirst;
        rangeLast  = pageLast;
      end
      OP_ERASE_SECT: begin
        opOk       = accessEn && !badAddr && !isFact;
        isErase    = 1'b1;
        rangeFirst = secFirst;
        rangeLast  = secLast;
      end
      OP_ERASE_ALL: begin
        opOk    = 1'b1;
        isErase = 1'b1;
      end
      default: opOk = 1'b0;
    endcase
  end

  assign startErase = take && opOk && isErase;

  always_comb begin
    strb           = '0;
    strb.rdLatch   = take && opOk && (cmdOp == OP_READ);
    strb.wrByte    = take && opOk && (cmdOp == OP_PROG_BYTE);
    strb.wrWord    = take && opOk && (cmdOp == OP_PROG_WORD);
    strb.eraseLoc  = (stateQ == ST_ERASE);
    strb.verifyLoc = (stateQ == ST_VERIFY);
  end

  // erase sequencer: page delay, erase walk, verify walk
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      walkAddr <= '0;
      firstQ   <= '0;
      lastQ    <= '0;
      delayQ   <= '0;
      errAccQ  <= 1'b0;
      eraseErr <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (startErase) begin
            firstQ   <= rangeFirst;
            lastQ    <= rangeLast;
            walkAddr <= rangeFirst;
            delayQ   <= DELAY_LOAD;
            errAccQ  <= 1'b0;
            eraseErr <= 1'b0;
            stateQ   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (delayQ == '0) stateQ <= ST_ERASE;
          else              delayQ <= delayQ - DW'(1);
        end
        ST_ERASE: begin
          if (atLast) begin
            walkAddr <= firstQ;
            stateQ   <= ST_VERIFY;
          end else begin
            walkAddr <= walkAddr + AW'(1);
            if (walkPageStart) begin
              delayQ <= DELAY_LOAD;
              stateQ <= ST_WAIT;
            end
          end
        end
        ST_VERIFY: begin
          errAccQ <= errAccQ || walkFail;
          if (atLast) begin
            eraseErr <= errAccQ || walkFail;
            stateQ   <= ST_IDLE;
          end else begin
            walkAddr <= walkAddr + AW'(1);
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // responses and sticky rejection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspErr      <= 1'b0;
      cmdRejected <= 1'b0;
    end else begin
      rspValid <= take;
      rspErr   <= take && !opOk;
      if (cmdValid && !isIdle) cmdRejected <= 1'b1;
      else if (rejClr)         cmdRejected <= 1'b0;
    end
  end

  // R9: start of an erase is acknowledged without error
  p_start_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (rspValid && !rspErr));

  // R9: the error flag only moves at erase start or end
  p_err_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(eraseErr));

  // R10: with access disabled, only the whole-array erase is taken
  p_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && !accessEn && (cmdOp != 3'd5)) |=> (rspValid && rspErr && !busy));

  // R11: a command during an erase produces no response
  p_busy_silent_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |=> !rspValid);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int MAIN_PAGE_BYTES        = 16,
  parameter int MAIN_PAGES_PER_SECTION = 2,
  parameter int MAIN_SECTIONS          = 2,
  parameter int INFO_PAGE_BYTES        = 8,
  parameter int INFO_PAGES_PER_SECTION = 2,
  parameter int INFO_SECTIONS          = 2,
  parameter int FACTORY_BYTES          = 8,
  parameter int PAGE_DELAY             = 3,
  localparam int ARRAY_BYTES = MAIN_PAGE_BYTES * MAIN_PAGES_PER_SECTION * MAIN_SECTIONS
                             + INFO_PAGE_BYTES * INFO_PAGES_PER_SECTION * INFO_SECTIONS,
  localparam int TOTAL_BYTES = ARRAY_BYTES + FACTORY_BYTES,
  localparam int AW          = $clog2(TOTAL_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  input  logic [15:0]   cmdData,
  input  logic          accessEn,
  input  logic          rejClr,
  input  logic          faultEn,
  input  logic [AW-1:0] faultAddr,
  output logic          rspValid,
  output logic          rspErr,
  output logic [7:0]    rdData,
  output logic          busy,
  output logic          eraseErr,
  output logic          cmdRejected
);

  strobe_t       strb;
  region_e       region;
  logic [AW-1:0] pageFirst;
  logic [AW-1:0] pageLast;
  logic [AW-1:0] secFirst;
  logic [AW-1:0] secLast;
  logic [AW-1:0] walkAddr;
  logic [AW-1:0] walkNext;
  logic          walkPageStart;
  logic          progLo;
  logic          progHi;
  logic          walkFail;

  assign walkNext = walkAddr + AW'(1);

  flash_addr_map #(
    .MAIN_PAGE_BYTES       (MAIN_PAGE_BYTES),
    .MAIN_PAGES_PER_SECTION(MAIN_PAGES_PER_SECTION),
    .MAIN_SECTIONS         (MAIN_SECTIONS),
    .INFO_PAGE_BYTES       (INFO_PAGE_BYTES),
    .INFO_PAGES_PER_SECTION(INFO_PAGES_PER_SECTION),
    .INFO_SECTIONS         (INFO_SECTIONS),
    .FACTORY_BYTES         (FACTORY_BYTES),
    .AW                    (AW)
  ) uMap (
    .cmdAddr      (cmdAddr),
    .walkNext     (walkNext),
    .region       (region),
    .pageFirst    (pageFirst),
    .pageLast     (pageLast),
    .secFirst     (secFirst),
    .secLast      (secLast),
    .walkPageStart(walkPageStart)
  );

  flash_control #(
    .AW         (AW),
    .ARRAY_BYTES(ARRAY_BYTES),
    .PAGE_DELAY (PAGE_DELAY)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdOp        (cmdOp),
    .cmdAddrLsb   (cmdAddr[0]),
    .accessEn     (accessEn),
    .rejClr       (rejClr),
    .region       (region),
    .pageFirst    (pageFirst),
    .pageLast     (pageLast),
    .secFirst     (secFirst),
    .secLast      (secLast),
    .walkPageStart(walkPageStart),
    .progLo       (progLo),
    .progHi       (progHi),
    .walkFail     (walkFail),
    .strb         (strb),
    .walkAddr     (walkAddr),
    .busy         (busy),
    .rspValid     (rspValid),
    .rspErr       (rspErr),
    .eraseErr     (eraseErr),
    .cmdRejected  (cmdRejected)
  );

  flash_datapath #(
    .TOTAL_BYTES(TOTAL_BYTES),
    .FACT_BASE  (ARRAY_BYTES),
    .AW         (AW)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .walkAddr (walkAddr),
    .faultEn  (faultEn),
    .faultAddr(faultAddr),
    .rdData   (rdData),
    .progLo   (progLo),
    .progHi   (progHi),
    .walkFail (walkFail)
  );

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;

  localparam int D     = 3;
  localparam int MAINB = 64;
  localparam int ARRB  = 96;
  localparam int TOTB  = 104;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [6:0]  cmdAddr = '0;
  logic [15:0] cmdData = '0;
  logic        accessEn = 1'b0;
  logic        rejClr = 1'b0;
  logic        faultEn = 1'b0;
  logic [6:0]  faultAddr = '0;
  logic        rspValid, rspErr, busy, eraseErr, cmdRejected;
  logic [7:0]  rdData;

  flash_cmd_ctrl #(.PAGE_DELAY(D)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .accessEn(accessEn), .rejClr(rejClr), .faultEn(faultEn),
    .faultAddr(faultAddr), .rspValid(rspValid), .rspErr(rspErr), .rdData(rdData),
    .busy(busy), .eraseErr(eraseErr), .cmdRejected(cmdRejected));

  always #10 clk = ~clk;

  typedef struct {
    logic       err;
    logic       chk;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t       q[$];
  logic [7:0] mdl [TOTB];
  bit         prg [TOTB];
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rspValid === 1'b1) begin
      if (q.size() == 0) begin
        check(0, "R11 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rspErr === e.err, {e.tag, " rspErr"}, int'(rspErr), int'(e.err));
        if (e.chk) check(rdData === e.data, {e.tag, " rdData"}, int'(rdData), int'(e.data));
      end
    end
  end

  function automatic bit expOk(int op, int a);
    bit inR, fact, pr;
    inR  = (a < TOTB);
    fact = (a >= ARRB) && inR;
    pr   = inR ? prg[a] : 1'b0;
    case (op)
      0: return accessEn && inR;
      1: return accessEn && inR && !fact && !pr;
      2: return accessEn && inR && !fact && (a % 2 == 0) && !pr && !prg[a+1];
      3, 4: return accessEn && inR && !fact;
      5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(int op, int a, logic [15:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdAddr = 7'(a); cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic send(int op, int a, logic [15:0] d, string tag);
    exp_t e;
    bit ok;
    ok     = expOk(op, a);
    e.err  = !ok;
    e.chk  = ok && (op == 0);
    e.data = (a < TOTB) ? mdl[a] : 8'h00;
    e.tag  = tag;
    q.push_back(e);
    if (ok && op == 1) begin mdl[a] &= d[7:0]; prg[a] = 1; end
    if (ok && op == 2) begin
      mdl[a] &= d[7:0]; prg[a] = 1;
      mdl[a+1] &= d[15:8]; prg[a+1] = 1;
    end
    drive(op, a, d);
  endtask

  task automatic eraseRange(int op, int a, output int lo, output int hi, output int cyc);
    if (op == 5) begin lo = 0; hi = ARRB - 1; end
    else if (a < MAINB) begin
      int sz;
      sz = (op == 3) ? 16 : 32;
      lo = a - a % sz; hi = lo + sz - 1;
    end else begin
      int sz;
      sz = (op == 3) ? 8 : 16;
      lo = MAINB + (a - MAINB) - (a - MAINB) % sz; hi = lo + sz - 1;
    end
    cyc = 0;
    for (int i = lo; i <= hi; i++) begin
      if ((i < MAINB) ? (i % 16 == 0) : ((i - MAINB) % 8 == 0)) cyc += D;
      cyc += 2;
    end
  endtask

  task automatic finishErase(int lo, int hi, int remain, string tag);
    int  n;
    bit  expErr;
    n = 0;
    while (busy === 1'b1 && n < 5000) begin n++; @(negedge clk); end
    check(n == remain, {tag, " R9 busy cycles"}, n, remain);
    expErr = faultEn && (int'(faultAddr) >= lo) && (int'(faultAddr) <= hi);
    check(eraseErr === expErr, {tag, " R9 eraseErr"}, int'(eraseErr), int'(expErr));
    for (int i = lo; i <= hi; i++) begin
      mdl[i] = (faultEn && int'(faultAddr) == i) ? 8'h00 : 8'hFF;
      prg[i] = 0;
    end
  endtask

  task automatic doErase(int op, int a, string tag);
    int lo, hi, cyc;
    eraseRange(op, a, lo, hi, cyc);
    send(op, a, 16'h0, tag);
    check(busy === 1'b1, {tag, " R9 busy rises"}, int'(busy), 1);
    finishErase(lo, hi, cyc, tag);
  endtask

  task automatic rd(int a, string tag);
    send(0, a, 16'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lo, hi, cyc;
    for (int i = 0; i < TOTB; i++) begin
      mdl[i] = (i >= ARRB) ? 8'(8'hA0 + i - ARRB) : 8'hFF;
      prg[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(eraseErr === 1'b0, "R1 eraseErr", int'(eraseErr), 0);
    check(cmdRejected === 1'b0, "R1 cmdRejected", int'(cmdRejected), 0);
    check(rspValid === 1'b0, "R1 rspValid", int'(rspValid), 0);

    // R10: disabled access refuses reads and programs
    rd(5, "R10 read disabled");
    send(1, 5, 16'h00, "R10 program disabled");
    accessEn = 1'b1;

    // R1/R2 reads
    rd(5, "R1 R2 main read");
    rd(70, "R1 R2 info read");
    rd(100, "R1 R12 factory read");

    // R3 program clears only
    send(1, 5, 16'h00F0, "R3 program");
    rd(5, "R3 readback");
    send(1, 5, 16'h000F, "R5 second program");
    rd(5, "R5 unchanged");
    send(1, 6, 16'h003C, "R3 program 6");
    send(1, 20, 16'h0055, "R6 neighbour prog");

    // R4 word program
    send(2, 8, 16'h1234, "R4 word");
    rd(8, "R4 low byte");
    rd(9, "R4 high byte");
    send(2, 11, 16'h0000, "R4 odd address");
    rd(11, "R4 odd unchanged");
    send(2, 6, 16'h0000, "R5 word overlap");
    rd(7, "R5 word untouched");

    // R6 main page erase
    doErase(3, 7, "R6 main page");
    rd(5, "R6 erased");
    rd(9, "R6 erased word");
    rd(20, "R6 neighbour kept");
    send(1, 5, 16'h0011, "R6 reprogram");
    rd(5, "R6 reprogram read");

    // R6 info page erase
    send(1, 70, 16'h0000, "R6 info prog");
    send(1, 72, 16'h0000, "R6 info neighbour");
    doErase(3, 66, "R6 info page");
    rd(70, "R6 info erased");
    rd(72, "R6 info kept");

    // R7 section erases
    send(1, 81, 16'h0001, "R7 prog 81");
    send(1, 90, 16'h0002, "R7 prog 90");
    doErase(4, 80, "R7 info section");
    rd(81, "R7 erased 81");
    rd(90, "R7 erased 90");
    rd(72, "R7 other section kept");
    send(1, 40, 16'h0000, "R7 prog 40");
    send(1, 31, 16'h0000, "R7 prog 31");
    doErase(4, 50, "R7 main section");
    rd(40, "R7 erased 40");
    rd(31, "R7 kept 31");

    // R9 verify fault
    faultEn = 1'b1; faultAddr = 7'd3;
    doErase(3, 0, "R9 fault erase");
    rd(3, "R9 stuck byte");
    faultEn = 1'b0;
    doErase(3, 0, "R9 clean erase");
    rd(3, "R9 recovered byte");

    // R11 command during busy
    eraseRange(3, 32, lo, hi, cyc);
    send(3, 32, 16'h0, "R11 erase");
    drive(0, 5, 16'h0);
    check(cmdRejected === 1'b1, "R11 rejected set", int'(cmdRejected), 1);
    finishErase(lo, hi, cyc - 2, "R11 erase");
    check(cmdRejected === 1'b1, "R11 sticky", int'(cmdRejected), 1);
    @(negedge clk); rejClr = 1'b1;
    @(negedge clk); rejClr = 1'b0;
    check(cmdRejected === 1'b0, "R11 cleared", int'(cmdRejected), 0);

    // R12 refusals
    send(1, 100, 16'h0000, "R12 factory program");
    send(3, 100, 16'h0, "R12 factory page erase");
    send(4, 98, 16'h0, "R12 factory section erase");
    rd(120, "R12 out of range");
    send(7, 5, 16'h0, "R12 bad opcode");
    send(6, 5, 16'h0, "R12 bad opcode 6");
    rd(100, "R12 factory intact");

    // R10 gate and R8 whole-array erase
    accessEn = 1'b0;
    send(3, 5, 16'h0, "R10 page erase disabled");
    send(4, 5, 16'h0, "R10 section erase disabled");
    doErase(5, 0, "R8 whole array");
    accessEn = 1'b1;
    rd(20, "R8 main erased");
    rd(72, "R8 info erased");
    rd(96, "R8 factory kept");
    rd(103, "R8 factory end kept");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 all responses seen", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule